// File: doc/BRIEF.md
# Registered Two-Way Byte Port with Parity and Ready Flags

This block is an 8-bit port that moves data both ways between two buses, called side A and side B. Each direction has its own holding register. A load strobe paired with an active-low load enable fills the register. Filling it raises a ready flag. The reading side then turns on its output enable, takes the byte, and turns the enable off again. That last edge clears the flag, which gives a demand-response handshake in each direction.

Bytes travelling from A to B leave with a generated odd-parity bit. Bytes travelling from B to A arrive with a parity bit. That bit is stored beside the byte and checked against it, and the result appears on an active-low error output.

The block runs on one system clock. The strobes, load enables and output enables are asynchronous to it. A parameterised synchroniser brings them into the clock domain and detects their rising edges, so every change of state happens on a system clock edge. Neither bus is a tri-state pin. Each one is a data output paired with a drive-enable output, and the enclosing logic builds the pad from them. The data outputs always show the register contents, and the drive enable says whether they are valid on the bus.

Top module: `regxcvr_top`

## Requirements
- R1: On a synchronised rising edge of `ab_stb`, the A-to-B register loads `a_in` if `ab_ld_n` is LOW. If `ab_ld_n` is HIGH, the register and `ab_rdy` are left unchanged.
- R2: On a synchronised rising edge of `ba_stb`, the B-to-A register loads `b_in` and the parity register loads `par_in` if `ba_ld_n` is LOW. If `ba_ld_n` is HIGH, neither register changes.
- R3: Every load of a direction's register sets that direction's ready flag (`ab_rdy` or `ba_rdy`) HIGH.
- R4: A ready flag is cleared only by a LOW-to-HIGH transition of its own direction's output enable (`ab_oe_n` for `ab_rdy`, `ba_oe_n` for `ba_rdy`). While the enable is held steady, the flag keeps its value.
- R5: `b_drv` and `par_drv` are HIGH exactly while the synchronised `ab_oe_n` is LOW, and `b_out` carries the A-to-B register.
- R6: `a_drv` is HIGH exactly while the synchronised `ba_oe_n` is LOW, and `a_out` carries the B-to-A register.
- R7: `par_out` is HIGH when the A-to-B register holds an even number of ones, counting zero ones as even. It is LOW when the count is odd.
- R8: While `ba_oe_n` is LOW, `err_n` is HIGH when the eight data bits of the B-to-A register plus the stored parity bit hold an odd number of ones. It is LOW when that total is even.
- R9: While `ba_oe_n` is HIGH, `err_n` is HIGH whatever the stored contents.
- R10: If a load and a flag-clearing output-enable rising edge are seen in the same clock cycle, the load wins and the flag ends HIGH.
- R11: A synchronous active-high `rst` clears both data registers, the parity register and both flags. Both drive enables are then LOW, `par_out` is HIGH and `err_n` is HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DW | Side A data into the A-to-B register |
| ab_stb | input | 1 | A-to-B load strobe (acts on its rising edge) |
| ab_ld_n | input | 1 | A-to-B load enable, active LOW |
| ab_oe_n | input | 1 | Side B output enable, active LOW; its rising edge clears `ab_rdy` |
| b_out | output | DW | A-to-B register contents toward side B |
| b_drv | output | 1 | Side B drive enable |
| par_out | output | 1 | Generated odd-parity bit |
| par_drv | output | 1 | Parity drive enable |
| ab_rdy | output | 1 | A-to-B ready flag |
| b_in | input | DW | Side B data into the B-to-A register |
| par_in | input | 1 | Incoming parity bit |
| ba_stb | input | 1 | B-to-A load strobe (acts on its rising edge) |
| ba_ld_n | input | 1 | B-to-A load enable, active LOW |
| ba_oe_n | input | 1 | Side A output enable, active LOW; its rising edge clears `ba_rdy` |
| a_out | output | DW | B-to-A register contents toward side A |
| a_drv | output | 1 | Side A drive enable |
| ba_rdy | output | 1 | B-to-A ready flag |
| err_n | output | 1 | Parity check result, LOW on an even total |

## Verification
The synchroniser is SYNC_STAGES deep (two flops by default). With the default depth, the drive enables follow an output-enable change on the second rising clock edge after the input moves. Register loads, flag changes, `par_out` and the contents part of `err_n` change on the third edge, one stage later, because the edge detector must see both the old and the new synchronised level. The bench driver holds every stimulus for at least four clock cycles. It then waits four more cycles before it pushes the expected item, so the monitor compares at a falling edge well after both deadlines. Data inputs are held stable from before the strobe until after the strobe falls, so the capture edge always samples settled data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Widest vector the parity helper accepts; narrower inputs are zero-extended.
    localparam int PAR_MAX = 64;

    // Asynchronous control inputs, carried together through the synchroniser.
    typedef struct packed {
        logic ab_stb;
        logic ab_ld_n;
        logic ab_oe_n;
        logic ba_stb;
        logic ba_ld_n;
        logic ba_oe_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Quiet state: strobes low, active-low enables released.
    localparam ctl_t CTL_IDLE = '{
        ab_stb:  1'b0,
        ab_ld_n: 1'b1,
        ab_oe_n: 1'b1,
        ba_stb:  1'b0,
        ba_ld_n: 1'b1,
        ba_oe_n: 1'b1
    };

    // Decoded per-direction actions for one clock cycle.
    typedef struct packed {
        logic load;
        logic clear;
        logic drive;
    } lane_ctl_t;

    // One when the vector holds an odd count of ones.
    function automatic logic odd_ones(input logic [PAR_MAX-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int          W       = 6,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[LAST];
        end
    end

    assign q    = chain[LAST];
    assign rise = chain[LAST] & ~prev;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  xcvr_pkg::lane_ctl_t   ctl,
    input  logic [W-1:0]          d,
    output logic [W-1:0]          q,
    output logic                  rdy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            rdy <= 1'b0;
        end else begin
            if (ctl.load) q <= d;
            // A load in the same cycle as a clear leaves the flag set.
            if (ctl.load)       rdy <= 1'b1;
            else if (ctl.clear) rdy <= 1'b0;
        end
    end

endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    input  logic          ab_stb,
    input  logic          ab_ld_n,
    input  logic          ab_oe_n,
    output logic [DW-1:0] b_out,
    output logic          b_drv,
    output logic          par_out,
    output logic          par_drv,
    output logic          ab_rdy,
    input  logic [DW-1:0] b_in,
    input  logic          par_in,
    input  logic          ba_stb,
    input  logic          ba_ld_n,
    input  logic          ba_oe_n,
    output logic [DW-1:0] a_out,
    output logic          a_drv,
    output logic          ba_rdy,
    output logic          err_n
);
    import xcvr_pkg::*;

    localparam int BA_W = DW + 1;   // data byte plus stored parity bit
    localparam int PW   = PAR_MAX;

    ctl_t ctl_raw, ctl_lvl, ctl_rise;
    logic [CTL_W-1:0] lvl_vec, rise_vec;

    assign ctl_raw = '{
        ab_stb:  ab_stb,
        ab_ld_n: ab_ld_n,
        ab_oe_n: ab_oe_n,
        ba_stb:  ba_stb,
        ba_ld_n: ba_ld_n,
        ba_oe_n: ba_oe_n
    };

    xcvr_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (ctl_raw),
        .q    (lvl_vec),
        .rise (rise_vec)
    );

    assign ctl_lvl  = ctl_t'(lvl_vec);
    assign ctl_rise = ctl_t'(rise_vec);

    lane_ctl_t ab_ctl, ba_ctl;

    always_comb begin
        ab_ctl.load  = ctl_rise.ab_stb & ~ctl_lvl.ab_ld_n;
        ab_ctl.clear = ctl_rise.ab_oe_n;
        ab_ctl.drive = ~ctl_lvl.ab_oe_n;
        ba_ctl.load  = ctl_rise.ba_stb & ~ctl_lvl.ba_ld_n;
        ba_ctl.clear = ctl_rise.ba_oe_n;
        ba_ctl.drive = ~ctl_lvl.ba_oe_n;
    end

    logic [DW-1:0]   ab_q;
    logic [BA_W-1:0] ba_q;

    xcvr_lane #(.W(DW)) u_ab (
        .clk (clk),
        .rst (rst),
        .ctl (ab_ctl),
        .d   (a_in),
        .q   (ab_q),
        .rdy (ab_rdy)
    );

    xcvr_lane #(.W(BA_W)) u_ba (
        .clk (clk),
        .rst (rst),
        .ctl (ba_ctl),
        .d   ({par_in, b_in}),
        .q   (ba_q),
        .rdy (ba_rdy)
    );

    logic [PW-1:0] ab_ext, ba_ext;
    assign ab_ext = PW'(ab_q);
    assign ba_ext = PW'(ba_q);

    assign b_out   = ab_q;
    assign b_drv   = ab_ctl.drive;
    assign par_out = ~odd_ones(ab_ext);
    assign par_drv = ab_ctl.drive;

    assign a_out   = ba_q[DW-1:0];
    assign a_drv   = ba_ctl.drive;
    assign err_n   = ba_ctl.drive ? odd_ones(ba_ext) : 1'b1;

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] b_out,
    input logic          b_drv,
    input logic          par_out,
    input logic          par_drv,
    input logic          ab_rdy,
    input logic [DW-1:0] a_out,
    input logic          a_drv,
    input logic          ba_rdy,
    input logic          err_n
);
    // R1/R3: the A-to-B contents only move on a load, which also raises the flag
    p_ab_move_sets_flag_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(b_out) |-> ab_rdy);

    // R2/R3: the B-to-A contents only move on a load, which also raises the flag
    p_ba_move_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(a_out) |-> ba_rdy);

    // R4: the A-to-B flag falls one cycle after the B drive enable has dropped
    p_ab_clear_after_oe_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ab_rdy) |-> (!$past(b_drv) && $past(b_drv, 2)));

    // R4: the B-to-A flag falls one cycle after the A drive enable has dropped
    p_ba_clear_after_oe_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ba_rdy) |-> (!$past(a_drv) && $past(a_drv, 2)));

    // R5: parity is driven together with the B bus
    p_par_with_bus_r5: assert property (@(posedge clk) disable iff (rst)
        par_drv == b_drv);

    // R7: the parity pin makes the total count of ones across the B bus odd
    p_par_odd_total_r7: assert property (@(posedge clk) disable iff (rst)
        (^{b_out, par_out}) == 1'b1);

    // R9: a released A bus never reports an error
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !a_drv |-> err_n);

endmodule

bind regxcvr_top xcvr_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .b_out   (b_out),
    .b_drv   (b_drv),
    .par_out (par_out),
    .par_drv (par_drv),
    .ab_rdy  (ab_rdy),
    .a_out   (a_out),
    .a_drv   (a_drv),
    .ba_rdy  (ba_rdy),
    .err_n   (err_n)
);

// File: tb/test_regxcvr_top.sv
module test_regxcvr_top;
    localparam int  DW      = 8;
    localparam time CLK_PER = 10ns;
    localparam int  SETTLE  = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] a_in, b_in;
    logic          ab_stb, ab_ld_n, ab_oe_n;
    logic          ba_stb, ba_ld_n, ba_oe_n, par_in;
    logic [DW-1:0] b_out, a_out;
    logic          b_drv, par_out, par_drv, ab_rdy;
    logic          a_drv, ba_rdy, err_n;

    always #(CLK_PER/2) clk = ~clk;

    regxcvr_top #(.DW(DW), .SYNC_STAGES(2)) i_regxcvr_top (
        .clk(clk), .rst(rst),
        .a_in(a_in), .ab_stb(ab_stb), .ab_ld_n(ab_ld_n), .ab_oe_n(ab_oe_n),
        .b_out(b_out), .b_drv(b_drv), .par_out(par_out), .par_drv(par_drv),
        .ab_rdy(ab_rdy),
        .b_in(b_in), .par_in(par_in), .ba_stb(ba_stb), .ba_ld_n(ba_ld_n),
        .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_drv(a_drv), .ba_rdy(ba_rdy), .err_n(err_n)
    );

    typedef struct {
        string         tag;
        logic [DW-1:0] b_out, a_out;
        logic          b_drv, par_out, par_drv, ab_rdy, a_drv, ba_rdy, err_n;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    // reference state, kept from the requirements
    logic [DW-1:0] m_ab, m_ba;
    logic          m_par, m_ab_rdy, m_ba_rdy, m_ab_oe_n, m_ba_oe_n;

    task automatic cmp(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            cmp(e.tag, "b_out",   32'(b_out),   32'(e.b_out));
            cmp(e.tag, "b_drv",   32'(b_drv),   32'(e.b_drv));
            cmp(e.tag, "par_out", 32'(par_out), 32'(e.par_out));
            cmp(e.tag, "par_drv", 32'(par_drv), 32'(e.par_drv));
            cmp(e.tag, "ab_rdy",  32'(ab_rdy),  32'(e.ab_rdy));
            cmp(e.tag, "a_out",   32'(a_out),   32'(e.a_out));
            cmp(e.tag, "a_drv",   32'(a_drv),   32'(e.a_drv));
            cmp(e.tag, "ba_rdy",  32'(ba_rdy),  32'(e.ba_rdy));
            cmp(e.tag, "err_n",   32'(err_n),   32'(e.err_n));
        end
    end

    // driver: push what the requirements predict after the outputs have settled
    task automatic expect_now(string tag);
        exp_t e;
        repeat (SETTLE) @(negedge clk);
        e.tag     = tag;
        e.b_out   = m_ab;
        e.b_drv   = ~m_ab_oe_n;
        e.par_drv = ~m_ab_oe_n;
        e.par_out = ~(^m_ab);                                   // R7
        e.ab_rdy  = m_ab_rdy;
        e.a_out   = m_ba;
        e.a_drv   = ~m_ba_oe_n;
        e.ba_rdy  = m_ba_rdy;
        e.err_n   = m_ba_oe_n ? 1'b1 : (^{m_par, m_ba});        // R8, R9
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ab = '0; m_ba = '0; m_par = 1'b0; m_ab_rdy = 1'b0; m_ba_rdy = 1'b0;
    endtask

    task automatic load_ab(logic [DW-1:0] d, logic en_n);
        @(negedge clk);
        a_in = d; ab_ld_n = en_n;
        @(negedge clk);
        ab_stb = 1'b1;
        repeat (SETTLE) @(negedge clk);
        ab_stb = 1'b0;
        repeat (SETTLE) @(negedge clk);
        ab_ld_n = 1'b1;
        if (!en_n) begin m_ab = d; m_ab_rdy = 1'b1; end
    endtask

    task automatic load_ba(logic [DW-1:0] d, logic p, logic en_n);
        @(negedge clk);
        b_in = d; par_in = p; ba_ld_n = en_n;
        @(negedge clk);
        ba_stb = 1'b1;
        repeat (SETTLE) @(negedge clk);
        ba_stb = 1'b0;
        repeat (SETTLE) @(negedge clk);
        ba_ld_n = 1'b1;
        if (!en_n) begin m_ba = d; m_par = p; m_ba_rdy = 1'b1; end
    endtask

    task automatic set_ab_oe(logic v);
        @(negedge clk);
        if (m_ab_oe_n == 1'b0 && v == 1'b1) m_ab_rdy = 1'b0;
        ab_oe_n = v; m_ab_oe_n = v;
    endtask

    task automatic set_ba_oe(logic v);
        @(negedge clk);
        if (m_ba_oe_n == 1'b0 && v == 1'b1) m_ba_rdy = 1'b0;
        ba_oe_n = v; m_ba_oe_n = v;
    endtask

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0; par_in = 1'b0;
        ab_stb = 1'b0; ab_ld_n = 1'b1; ab_oe_n = 1'b1;
        ba_stb = 1'b0; ba_ld_n = 1'b1; ba_oe_n = 1'b1;
        m_ab_oe_n = 1'b1; m_ba_oe_n = 1'b1;
        do_reset();
        expect_now("R11 reset state");

        load_ab(8'hA5, 1'b0);
        expect_now("R1 R3 A-to-B load");
        set_ab_oe(1'b0);
        expect_now("R5 R7 even count drives parity high, R4 flag held");
        set_ab_oe(1'b1);
        expect_now("R4 flag cleared by enable rise");

        load_ab(8'h3C, 1'b1);
        expect_now("R1 load ignored with enable high");
        load_ab(8'h07, 1'b0);
        expect_now("R7 odd count parity low");
        load_ab(8'h00, 1'b0);
        expect_now("R7 zero ones parity high");

        load_ba(8'h81, 1'b1, 1'b0);
        expect_now("R2 R3 B-to-A load, R9 error quiet while released");
        set_ba_oe(1'b0);
        expect_now("R6 R8 odd total error high");
        load_ba(8'h81, 1'b0, 1'b0);
        expect_now("R8 even total error low");
        load_ba(8'hFF, 1'b1, 1'b1);
        expect_now("R2 load ignored with enable high");
        set_ba_oe(1'b1);
        expect_now("R9 R4 released bus forces error high, flag cleared");

        // load and flag-clearing enable rise seen in the same cycle
        set_ab_oe(1'b0);
        expect_now("R5 drive on");
        @(negedge clk);
        a_in = 8'h55; ab_ld_n = 1'b0;
        @(negedge clk);
        ab_stb = 1'b1; ab_oe_n = 1'b1;
        m_ab_oe_n = 1'b1; m_ab = 8'h55; m_ab_rdy = 1'b1;
        repeat (SETTLE) @(negedge clk);
        ab_stb = 1'b0;
        repeat (SETTLE) @(negedge clk);
        ab_ld_n = 1'b1;
        expect_now("R10 load wins over clear");

        load_ba(8'h12, 1'b1, 1'b0);
        do_reset();
        expect_now("R11 reset mid-run");

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired");
            end
            wait (done);
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule